// File: doc/BRIEF.md
# Crosspoint Routing Configuration Controller

This block keeps the routing state for a switch matrix in which each of 16 outputs connects to one of 16 inputs or to none. Each output's entry is five bits wide: a 4-bit source number and an enable bit. A host loads these entries in one of two ways. In serial mode it shifts an 80-bit word into a first-rank register. In parallel mode it writes a single entry by address. Both paths change only the first rank. A second rank of level-sensitive latches passes the first rank to the outputs while the update strobe and the chip enable are both low. Between updates, the second rank holds the outputs that are in use.

The top bit of the serial register is available as a serial output. Devices can be chained through it, so one long word programs several matrices. An asynchronous active-low reset clears both ranks, which disables every output. As a model of the switch fabric, the block also routes a vector of digital inputs to each enabled output.

Top module: `xpt_cfg_ctrl`

## Requirements
- R1: While `rst_n` is low, every `en_o` bit, every `route_o` bit and `sdo` are 0. After reset is released, an update pulse with no writes in between leaves all outputs disabled, because the first rank was cleared as well.
- R2: On each falling edge of `clk` with `ce_n` low and `mode_par` low (serial), `sdi` enters the first rank. Entries are sent from output 15 down to output 0. Within an entry the enable bit comes first, followed by select bits 3 down to 0. After 80 shifts, the output entries apply on update.
- R3: `sdo` is the bit that leaves the far end of the register on the next falling edge. Right after an 80-bit load it equals the first bit shifted in (the enable of output 15). With two devices chained, 160 shifts program both devices, and the data for the far device is sent first.
- R4: While `ce_n` is high, falling edges neither shift nor write, and a low `upd_n` does not change the outputs.
- R5: While `upd_n` is high, first-rank changes do not reach `sel_o` or `en_o`. A low `upd_n` together with a low `ce_n` copies the first rank to the outputs.
- R6: If `upd_n` and `ce_n` are low during shifting, the outputs follow each intermediate shifted state.
- R7: On a falling edge with `ce_n` low and `mode_par` high, `par_data` is written into entry `par_addr`. Bit 4 is the enable and bits 3:0 are the select. All other entries are unchanged.
- R8: `sel_o[4k+3:4k]` and `en_o[k]` carry entry k. `route_o[k]` equals `src_in[sel]` when entry k is enabled. Otherwise `route_o[k]` is 0 and the select is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Programming clock; both write paths act on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset; disables all outputs |
| ce_n | input | 1 | Active-low chip enable for shifting, writing and updating |
| mode_par | input | 1 | 0 selects serial loading, 1 selects parallel entry writes |
| upd_n | input | 1 | Active-low update strobe; second rank transparent while low |
| sdi | input | 1 | Serial data input |
| par_addr | input | 4 | Output number for a parallel write |
| par_data | input | 5 | Entry for a parallel write: bit 4 enable, bits 3:0 source |
| src_in | input | 16 | Digital inputs routed by the modeled matrix |
| sdo | output | 1 | Serial data output for chaining (top bit of first rank) |
| sel_o | output | 64 | Per-output source selects, 4 bits per output |
| en_o | output | 16 | Per-output enables |
| route_o | output | 16 | Modeled routing result per output |

## Verification
The first rank changes on the falling edge of `clk`, and `sdo` changes at that same edge. Because the second rank is a latch, `sel_o` and `en_o` change within the same half cycle when the strobe is open, and `route_o` follows `src_in` combinationally. The bench therefore drives every input 1 ns after a rising edge and samples 2 ns after a later rising edge, which is well clear of the falling edge that acts on the inputs. An update pulse opens and closes entirely between a rising and a falling edge, so no shift or write coincides with it unless a test (R6) arranges one on purpose.

// File: rtl/xpt_cfg_pkg.sv
`timescale 1ns/1ps
package xpt_cfg_pkg;
   localparam int XPT_DEF_OUTS = 16;
   localparam int XPT_DEF_INS  = 16;

   typedef enum logic {
      XPT_MODE_SERIAL   = 1'b0,
      XPT_MODE_PARALLEL = 1'b1
   } xpt_mode_e;

   typedef enum logic {
      XPT_MUX_INDEX  = 1'b0,
      XPT_MUX_ONEHOT = 1'b1
   } xpt_mux_e;
endpackage

// File: rtl/xpt_first_rank.sv
`timescale 1ns/1ps
module xpt_first_rank
   import xpt_cfg_pkg::*;
#(
   parameter int N_OUT  = XPT_DEF_OUTS,
   parameter int GRP_W  = 5,
   parameter int ADDR_W = $clog2(N_OUT),
   localparam int RANK_W = N_OUT * GRP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              mode_par,
   input  logic              sdi,
   input  logic [ADDR_W-1:0] par_addr,
   input  logic [GRP_W-1:0]  par_data,
   output logic [RANK_W-1:0] rank_o,
   output logic              sdo
);
   logic [GRP_W-1:0] grp_q [N_OUT];
   xpt_mode_e        mode;

   assign mode = xpt_mode_e'(mode_par);

   for (genvar g = 0; g < N_OUT; g++) begin : g_grp
      logic ser_in;
      logic hit;

      if (g == 0) begin : g_head
         assign ser_in = sdi;
      end else begin : g_link
         assign ser_in = grp_q[g-1][GRP_W-1];
      end

      assign hit = (par_addr == ADDR_W'(g));

      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) begin
            grp_q[g] <= '0;
         end else if (!ce_n) begin
            if (mode == XPT_MODE_SERIAL) begin
               grp_q[g] <= {grp_q[g][GRP_W-2:0], ser_in};
            end else if (hit) begin
               grp_q[g] <= par_data;
            end
         end
      end

      assign rank_o[g*GRP_W +: GRP_W] = grp_q[g];
   end

   assign sdo = grp_q[N_OUT-1][GRP_W-1];
endmodule

// File: rtl/xpt_update_rank.sv
`timescale 1ns/1ps
module xpt_update_rank #(
   parameter int W = 80
) (
   input  logic         rst_n,
   input  logic         ce_n,
   input  logic         upd_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic open_gate;

   assign open_gate = ~ce_n & ~upd_n;

   always_latch begin
      if (!rst_n) begin
         q <= '0;
      end else if (open_gate) begin
         q <= d;
      end
   end
endmodule

// File: rtl/xpt_route_mux.sv
`timescale 1ns/1ps
module xpt_route_mux
   import xpt_cfg_pkg::*;
#(
   parameter int       N_IN  = XPT_DEF_INS,
   parameter xpt_mux_e STYLE = XPT_MUX_INDEX,
   localparam int      SEL_W = $clog2(N_IN)
) (
   input  logic [N_IN-1:0]  src_in,
   input  logic [SEL_W-1:0] sel,
   input  logic             en,
   output logic             y
);
   if (STYLE == XPT_MUX_ONEHOT) begin : g_onehot
      logic [N_IN-1:0] dec;
      always_comb begin
         dec      = '0;
         dec[sel] = 1'b1;
      end
      assign y = en & (|(dec & src_in));
   end else begin : g_index
      assign y = en & src_in[sel];
   end
endmodule

// File: rtl/xpt_cfg_ctrl.sv
`timescale 1ns/1ps
module xpt_cfg_ctrl
   import xpt_cfg_pkg::*;
#(
   parameter int       N_OUT     = XPT_DEF_OUTS,
   parameter int       N_IN      = XPT_DEF_INS,
   parameter xpt_mux_e MUX_STYLE = XPT_MUX_INDEX,
   localparam int      SEL_W     = $clog2(N_IN),
   localparam int      ADDR_W    = $clog2(N_OUT),
   localparam int      GRP_W     = SEL_W + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ce_n,
   input  logic                   mode_par,
   input  logic                   upd_n,
   input  logic                   sdi,
   input  logic [ADDR_W-1:0]      par_addr,
   input  logic [GRP_W-1:0]       par_data,
   input  logic [N_IN-1:0]        src_in,
   output logic                   sdo,
   output logic [N_OUT*SEL_W-1:0] sel_o,
   output logic [N_OUT-1:0]       en_o,
   output logic [N_OUT-1:0]       route_o
);
   localparam int RANK_W = N_OUT * GRP_W;

   if (N_IN < 2 || (N_IN & (N_IN - 1)) != 0) begin : g_bad_ins
      $error("xpt_cfg_ctrl: N_IN must be a power of two of at least 2");
   end
   if (N_OUT < 2) begin : g_bad_outs
      $error("xpt_cfg_ctrl: N_OUT must be at least 2");
   end

   logic [RANK_W-1:0] rank1;
   logic [RANK_W-1:0] rank2;

   xpt_first_rank #(
      .N_OUT (N_OUT),
      .GRP_W (GRP_W),
      .ADDR_W(ADDR_W)
   ) u_rank1 (
      .clk     (clk),
      .rst_n   (rst_n),
      .ce_n    (ce_n),
      .mode_par(mode_par),
      .sdi     (sdi),
      .par_addr(par_addr),
      .par_data(par_data),
      .rank_o  (rank1),
      .sdo     (sdo)
   );

   xpt_update_rank #(
      .W(RANK_W)
   ) u_rank2 (
      .rst_n(rst_n),
      .ce_n (ce_n),
      .upd_n(upd_n),
      .d    (rank1),
      .q    (rank2)
   );

   for (genvar k = 0; k < N_OUT; k++) begin : g_out
      assign sel_o[k*SEL_W +: SEL_W] = rank2[k*GRP_W +: SEL_W];
      assign en_o[k]                 = rank2[k*GRP_W + SEL_W];

      xpt_route_mux #(
         .N_IN (N_IN),
         .STYLE(MUX_STYLE)
      ) u_mux (
         .src_in(src_in),
         .sel   (sel_o[k*SEL_W +: SEL_W]),
         .en    (en_o[k]),
         .y     (route_o[k])
      );
   end
endmodule

// File: rtl/xpt_cfg_ctrl_chk.sv
`timescale 1ns/1ps
module xpt_cfg_ctrl_chk #(
   parameter int  N_OUT  = 16,
   parameter int  N_IN   = 16,
   localparam int SEL_W  = $clog2(N_IN),
   localparam int ADDR_W = $clog2(N_OUT),
   localparam int GRP_W  = SEL_W + 1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   ce_n,
   input logic                   mode_par,
   input logic [ADDR_W-1:0]      par_addr,
   input logic                   sdo,
   input logic [N_OUT*SEL_W-1:0] sel_o,
   input logic [N_OUT-1:0]       en_o,
   input logic [N_OUT-1:0]       route_o
);
   p_reset_disables_r1: assert property (@(posedge clk)
      !rst_n |-> (en_o == '0) && (route_o == '0));

   p_reset_clears_sdo_r1: assert property (@(posedge clk)
      !rst_n |-> !sdo);

   p_route_off_when_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (route_o & ~en_o) == '0);

   p_ce_blocks_shift_r4: assert property (@(negedge clk) disable iff (!rst_n)
      ce_n |=> $stable(sdo));

   p_par_write_keeps_top_r7: assert property (@(negedge clk) disable iff (!rst_n)
      (mode_par && par_addr != ADDR_W'(N_OUT - 1)) |=> $stable(sdo));
endmodule

bind xpt_cfg_ctrl xpt_cfg_ctrl_chk #(
   .N_OUT(N_OUT),
   .N_IN (N_IN)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ce_n    (ce_n),
   .mode_par(mode_par),
   .par_addr(par_addr),
   .sdo     (sdo),
   .sel_o   (sel_o),
   .en_o    (en_o),
   .route_o (route_o)
);

// File: tb/xpt_cfg_ctrl_tb.sv
`timescale 1ns/1ps
module xpt_cfg_ctrl_tb;
   localparam int WD_CYCLES = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1;
   logic        mode_par = 1'b0;
   logic        upd_n = 1'b1;
   logic        sdi = 1'b0;
   logic [3:0]  par_addr = '0;
   logic [4:0]  par_data = '0;
   logic [15:0] src_in = '0;
   logic        sdo, sdo2;
   logic [63:0] sel_o, sel2;
   logic [15:0] en_o, en2, route_o, route2;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   logic [79:0] cur;   // expected applied configuration of u_dut
   logic [79:0] pend;  // expected first rank of u_dut

   always #4 clk = ~clk;

   xpt_cfg_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .mode_par(mode_par), .upd_n(upd_n),
      .sdi(sdi), .par_addr(par_addr), .par_data(par_data), .src_in(src_in),
      .sdo(sdo), .sel_o(sel_o), .en_o(en_o), .route_o(route_o));

   xpt_cfg_ctrl u_dut2 (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .mode_par(mode_par), .upd_n(upd_n),
      .sdi(sdo), .par_addr(par_addr), .par_data(par_data), .src_in(src_in),
      .sdo(sdo2), .sel_o(sel2), .en_o(en2), .route_o(route2));

   function automatic logic [79:0] mk_cfg(input int kind);
      logic [79:0] w = '0;
      for (int k = 0; k < 16; k++) begin
         logic       e;
         logic [3:0] s;
         case (kind)
            0: begin e = (k % 3 != 1); s = 4'((k * 5 + 3) % 16); end
            1: begin e = (k != 0);     s = 4'(15 - k);           end
            2: begin e = k[0];         s = 4'((k + 7) % 16);     end
            default: begin e = 1'b1;   s = 4'(k);                end
         endcase
         w[k*5 +: 5] = {e, s};
      end
      return w;
   endfunction

   function automatic logic [63:0] sel_of(input logic [79:0] w);
      logic [63:0] r;
      for (int k = 0; k < 16; k++) r[k*4 +: 4] = w[k*5 +: 4];
      return r;
   endfunction

   function automatic logic [15:0] en_of(input logic [79:0] w);
      logic [15:0] r;
      for (int k = 0; k < 16; k++) r[k] = w[k*5 + 4];
      return r;
   endfunction

   function automatic logic [15:0] route_of(input logic [79:0] w, input logic [15:0] s);
      logic [15:0] r;
      for (int k = 0; k < 16; k++) r[k] = w[k*5 + 4] & s[w[k*5 +: 4]];
      return r;
   endfunction

   task automatic chk(input string req, input string what, input logic [79:0] act,
                      input logic [79:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic chk_cfg(input string req, input logic [79:0] w);
      chk(req, "sel_o", 80'(sel_o), 80'(sel_of(w)));
      chk(req, "en_o", 80'(en_o), 80'(en_of(w)));
   endtask

   task automatic sample();
      @(posedge clk); #2;
   endtask

   task automatic shift_bit(input logic b, input logic ce);
      @(posedge clk); #1;
      ce_n = ce; mode_par = 1'b0; sdi = b;
   endtask

   task automatic idle();
      @(posedge clk); #1;
      ce_n = 1'b1; mode_par = 1'b0;
   endtask

   task automatic shift_word(input logic [79:0] w, input logic ce);
      for (int i = 79; i >= 0; i--) shift_bit(w[i], ce);
      idle();
   endtask

   task automatic par_write(input logic [3:0] a, input logic [4:0] d, input logic ce);
      @(posedge clk); #1;
      ce_n = ce; mode_par = 1'b1; par_addr = a; par_data = d;
      idle();
   endtask

   task automatic upd_pulse();
      @(posedge clk); #1;
      ce_n = 1'b0; upd_n = 1'b0;
      #2;
      ce_n = 1'b1; upd_n = 1'b1;
   endtask

   task automatic t_reset();
      src_in = 16'hFFFF;
      #1;
      chk("R1", "en_o in reset", 80'(en_o), 80'(0));
      chk("R1", "route_o in reset", 80'(route_o), 80'(0));
      chk("R1", "sdo in reset", 80'(sdo), 80'(0));
      @(posedge clk); #1 rst_n = 1'b1;
      cur = '0; pend = '0;
   endtask

   task automatic t_serial_load();
      pend = mk_cfg(0);
      shift_word(pend, 1'b0);
      sample();
      chk_cfg("R5 held before update", cur);
      upd_pulse();
      cur = pend;
      sample();
      chk_cfg("R2 serial word applied", cur);
      chk("R3", "sdo after 80 shifts", 80'(sdo), 80'(pend[79]));
   endtask

   task automatic t_ce_block();
      shift_word(mk_cfg(1), 1'b1);
      par_write(4'd3, 5'h1F, 1'b1);
      upd_pulse();
      sample();
      chk_cfg("R4 no shift or write with ce_n high", cur);
      chk("R4", "sdo unchanged", 80'(sdo), 80'(pend[79]));
   endtask

   task automatic t_update_gate();
      pend = mk_cfg(1);
      shift_word(pend, 1'b0);
      sample();
      chk_cfg("R5 strobe high holds outputs", cur);
      @(posedge clk); #1 upd_n = 1'b0;
      sample(); sample();
      chk_cfg("R4 strobe low with ce_n high holds", cur);
      @(posedge clk); #1 upd_n = 1'b1;
      upd_pulse();
      cur = pend;
      sample();
      chk_cfg("R5 update applies first rank", cur);
   endtask

   task automatic t_transparent();
      logic [2:0] bits = 3'b011;
      @(posedge clk); #1 upd_n = 1'b0;
      for (int i = 0; i < 3; i++) begin
         shift_bit(bits[i], 1'b0);
         @(posedge clk); #1 ce_n = 1'b1;
         #1;
         pend = {pend[78:0], bits[i]};
         cur = pend;
         chk_cfg("R6 outputs follow shifting", cur);
      end
      @(posedge clk); #1 upd_n = 1'b1;
   endtask

   task automatic t_parallel();
      par_write(4'd5, 5'b1_1001, 1'b0);
      par_write(4'd15, 5'b0_1111, 1'b0);
      par_write(4'd0, 5'b1_0000, 1'b0);
      pend[5*5 +: 5]  = 5'b1_1001;
      pend[15*5 +: 5] = 5'b0_1111;
      pend[0 +: 5]    = 5'b1_0000;
      sample();
      chk_cfg("R5 parallel write held", cur);
      chk("R7", "sdo after disabling output 15", 80'(sdo), 80'(0));
      upd_pulse();
      cur = pend;
      sample();
      chk_cfg("R7 parallel entries applied", cur);
   endtask

   task automatic t_route();
      for (int j = 0; j < 16; j++) begin
         src_in = 16'(1) << j;
         #1;
         chk("R8", $sformatf("route_o one-hot src %0d", j), 80'(route_o),
             80'(route_of(cur, src_in)));
      end
      src_in = 16'hFFFF; #1;
      chk("R8", "route_o all ones", 80'(route_o), 80'(en_of(cur)));
      chk("R8", "disabled output 15 ignores select", 80'(route_o[15]), 80'(0));
      src_in = 16'h0000; #1;
      chk("R8", "route_o all zeros", 80'(route_o), 80'(0));
      src_in = 16'hA5C3; #1;
      chk("R8", "route_o mixed", 80'(route_o), 80'(route_of(cur, src_in)));
   endtask

   task automatic t_chain();
      logic [79:0] far_w  = mk_cfg(2);
      logic [79:0] near_w = mk_cfg(3);
      for (int i = 79; i >= 0; i--) shift_bit(far_w[i], 1'b0);
      for (int i = 79; i >= 0; i--) shift_bit(near_w[i], 1'b0);
      idle();
      chk("R3", "near sdo after chain load", 80'(sdo), 80'(near_w[79]));
      chk("R3", "far sdo after chain load", 80'(sdo2), 80'(far_w[79]));
      upd_pulse();
      pend = near_w; cur = near_w;
      sample();
      chk_cfg("R3 near device", cur);
      chk("R3", "far sel", 80'(sel2), 80'(sel_of(far_w)));
      chk("R3", "far en", 80'(en2), 80'(en_of(far_w)));
   endtask

   task automatic t_reset_mid();
      @(posedge clk); #1 rst_n = 1'b0;
      #2;
      chk("R1", "en_o after mid reset", 80'(en_o), 80'(0));
      chk("R1", "far en after mid reset", 80'(en2), 80'(0));
      chk("R1", "sdo after mid reset", 80'(sdo), 80'(0));
      @(posedge clk); #1 rst_n = 1'b1;
      upd_pulse();
      sample();
      chk("R1", "first rank cleared en", 80'(en_o), 80'(0));
      chk("R1", "first rank cleared sel", 80'(sel_o), 80'(0));
   endtask

   initial begin
      t_reset();
      t_serial_load();
      t_ce_block();
      t_update_gate();
      t_transparent();
      t_parallel();
      t_route();
      t_chain();
      t_reset_mid();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #(WD_CYCLES * 8);
      if (!done) begin
         n_err++;
         $display("FAIL all watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule